// File: doc/BRIEF.md
# Cascaded Interrupt Request Arbiter

This block collects sixteen interrupt request lines into two banks of eight and picks one of them when the processor acknowledges. Lines 0 to 7 live in the primary bank, and lines 8 to 15 live in the secondary bank. The secondary bank reaches the primary bank through primary input 2, which acts as the cascade input. Each bank keeps a request register, an in-service register and a trigger-mode register. Each bank also takes a mask and a vector base from outside the block.

Agents raise and lower lines with single-cycle pulses. The block drives an interrupt-pending flag from the unmasked requests. On an acknowledge strobe it registers an 8-bit vector for the winning line and marks that line in service. An edge-mode request is consumed on acknowledge, while a level-mode request stays latched. Software retires in-service bits through a clear port that takes a bank select and an 8-bit clear mask. The trigger-mode registers are byte-wide. Each has a fixed write mask so that lines reserved by the system can never be switched to level mode.

Top module: `cascade_irq_arbiter`

## Requirements
- R1: A raise of line n, 0 to 7, sets primary request bit n. A raise of line n, 8 to 15, sets secondary request bit n-8 and also sets primary request bit 2 (the cascade input).
- R2: A lower of a line clears its request bit. When a raise and a lower hit the same line in one cycle, the raise wins. A raise or lower whose line number is 16 or above changes no register.
- R3: intPending is high exactly when (primary requests AND NOT primary mask) or (secondary requests AND NOT secondary mask) is nonzero.
- R4: On acknowledge, the lowest-numbered unmasked primary request wins. If that winner is bit 2, or if no primary request is unmasked, the lowest unmasked secondary request wins instead. The vector equals the winner's index within its bank plus that bank's base. It is loaded on the acknowledge edge and holds its value until the next acknowledge.
- R5: Acknowledge sets the in-service bit of the winner. A secondary winner also sets primary in-service bit 2.
- R6: Acknowledge clears the winner's request bit only when its trigger-mode bit is 0 (edge). If the trigger-mode bit is 1 (level), the request stays set.
- R7: Primary request bit 2 is cleared after a secondary lower, or after a secondary acknowledge, that leaves no unmasked secondary request.
- R8: An acknowledge with no winner returns a spurious vector and sets no in-service bit. The vector is the primary base plus 7 when nothing is unmasked. It is the secondary base plus 7 when primary bit 2 wins but no secondary request is unmasked.
- R9: A trigger-mode write with trigWrSel=0 stores data AND 0xF8 into the primary register. With trigWrSel=1 it stores data AND 0xDE into the secondary register.
- R10: An in-service clear with isrClrSel=0 (primary) or 1 (secondary) removes the in-service bits selected by isrClrMask on the next edge.
- R11: After reset, all requests, in-service bits and trigger modes are 0, the vector is 0 and intPending is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raiseValid | input | 1 | Raise pulse for raiseLine |
| raiseLine | input | 5 | Line number to raise |
| lowerValid | input | 1 | Lower pulse for lowerLine |
| lowerLine | input | 5 | Line number to lower |
| masterMask | input | 8 | Primary bank mask, 1 = masked |
| slaveMask | input | 8 | Secondary bank mask, 1 = masked |
| masterBase | input | 8 | Primary bank vector base |
| slaveBase | input | 8 | Secondary bank vector base |
| ack | input | 1 | Acknowledge strobe |
| isrClrEn | input | 1 | In-service clear strobe |
| isrClrSel | input | 1 | Clear bank: 0 primary, 1 secondary |
| isrClrMask | input | 8 | In-service bits to clear |
| trigWrEn | input | 1 | Trigger-mode write strobe |
| trigWrSel | input | 1 | Write bank: 0 primary, 1 secondary |
| trigWrData | input | 8 | Trigger-mode write data |
| intPending | output | 1 | Unmasked request present |
| vector | output | 8 | Registered vector of the last acknowledge |
| masterReq | output | 8 | Primary request register |
| slaveReq | output | 8 | Secondary request register |
| masterInService | output | 8 | Primary in-service register |
| slaveInService | output | 8 | Secondary in-service register |
| masterTrig | output | 8 | Primary trigger-mode register |
| slaveTrig | output | 8 | Secondary trigger-mode register |

## Verification
The bench drives the cascade path three ways: through primary bit 2 winning, through the fall-through when every primary request is masked, and through primary bit 2 winning with every secondary request masked. A design that routed these paths wrongly would return a primary-based vector, or would set in-service bits on a spurious acknowledge. It checks that a level-mode request survives acknowledge and that the cascade bit survives with it. A design that cleared the cascade bit unconditionally would drop the pending flag while secondary work remained. It also checks that a raise paired with a lower on the same line keeps the request set, that line numbers above 15 leave all registers untouched, and that writes of 0xFF to the trigger-mode registers read back as 0xF8 and 0xDE.

// File: rtl/cascade_arb_pkg.sv
package cascade_arb_pkg;

  localparam int BANK_LINES = 8;
  localparam int IDX_W      = $clog2(BANK_LINES);
  localparam int LINE_W     = $clog2(2 * BANK_LINES) + 1;

  typedef logic [BANK_LINES-1:0] bankVec_t;

  // control -> datapath strobes, all single-cycle
  typedef struct packed {
    bankVec_t raiseM;
    bankVec_t raiseS;
    bankVec_t lowerM;
    bankVec_t lowerS;
    bankVec_t clrM;
    bankVec_t clrS;
    logic     ackStb;
    logic     trigWrM;
    logic     trigWrS;
  } arbStrobes_t;

  typedef struct packed {
    logic             found;
    logic [IDX_W-1:0] idx;
  } pick_t;

  function automatic pick_t lowestSet(input bankVec_t v);
    pick_t r;
    r.found = 1'b0;
    r.idx   = '0;
    for (int i = BANK_LINES - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.found = 1'b1;
        r.idx   = IDX_W'(i);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import cascade_arb_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic              raiseValid,
  input  logic [LINE_W-1:0] raiseLine,
  input  logic              lowerValid,
  input  logic [LINE_W-1:0] lowerLine,
  input  logic              ack,
  input  logic              isrClrEn,
  input  logic              isrClrSel,
  input  bankVec_t          isrClrMask,
  input  logic              trigWrEn,
  input  logic              trigWrSel,
  output arbStrobes_t       stb
);

  localparam int TOTAL_LINES = 2 * BANK_LINES;

  logic     raiseOk, lowerOk, raiseHi, lowerHi;
  bankVec_t rawLowerM, rawLowerS;

  assign raiseOk = raiseValid && (int'(raiseLine) < TOTAL_LINES);
  assign lowerOk = lowerValid && (int'(lowerLine) < TOTAL_LINES);
  assign raiseHi = raiseLine[IDX_W];
  assign lowerHi = lowerLine[IDX_W];

  always_comb begin
    stb        = '0;
    rawLowerM  = '0;
    rawLowerS  = '0;
    if (raiseOk) begin
      if (raiseHi) begin
        stb.raiseS[raiseLine[IDX_W-1:0]] = 1'b1;
        stb.raiseM[CASCADE_LINE]          = 1'b1;
      end else begin
        stb.raiseM[raiseLine[IDX_W-1:0]] = 1'b1;
      end
    end
    if (lowerOk) begin
      if (lowerHi) rawLowerS[lowerLine[IDX_W-1:0]] = 1'b1;
      else         rawLowerM[lowerLine[IDX_W-1:0]] = 1'b1;
    end
    // raise beats lower on the same line
    stb.lowerM  = rawLowerM & ~stb.raiseM;
    stb.lowerS  = rawLowerS & ~stb.raiseS;
    stb.clrM    = (isrClrEn && !isrClrSel) ? isrClrMask : '0;
    stb.clrS    = (isrClrEn &&  isrClrSel) ? isrClrMask : '0;
    stb.ackStb  = ack;
    stb.trigWrM = trigWrEn && !trigWrSel;
    stb.trigWrS = trigWrEn &&  trigWrSel;
  end

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import cascade_arb_pkg::*;
#(
  parameter int       VEC_W        = 8,
  parameter int       CASCADE_LINE = 2,
  parameter bankVec_t TRIG_MASK_M  = 8'hF8,
  parameter bankVec_t TRIG_MASK_S  = 8'hDE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  arbStrobes_t      stb,
  input  bankVec_t         masterMask,
  input  bankVec_t         slaveMask,
  input  logic [VEC_W-1:0] masterBase,
  input  logic [VEC_W-1:0] slaveBase,
  input  bankVec_t         trigWrData,
  output logic             intPending,
  output logic [VEC_W-1:0] vector,
  output bankVec_t         masterReq,
  output bankVec_t         slaveReq,
  output bankVec_t         masterInService,
  output bankVec_t         slaveInService,
  output bankVec_t         masterTrig,
  output bankVec_t         slaveTrig
);

  localparam logic [VEC_W-1:0] LAST_OFS = VEC_W'(BANK_LINES - 1);
  localparam bankVec_t CAS_BIT = bankVec_t'(1) << CASCADE_LINE;

  bankVec_t mReq, sReq, mIsr, sIsr, mTrig, sTrig;
  logic [VEC_W-1:0] vecQ, vecD;

  bankVec_t mUnm, sUnm, mAck, sAck;
  pick_t    mPick, sPick;
  logic     useSlave, slaveHit;

  // arbitration over current register state
  always_comb begin
    mUnm     = mReq & ~masterMask;
    sUnm     = sReq & ~slaveMask;
    mPick    = lowestSet(mUnm);
    sPick    = lowestSet(sUnm);
    useSlave = (mPick.found && (int'(mPick.idx) == CASCADE_LINE)) ||
               (!mPick.found && sPick.found);
    mAck     = '0;
    sAck     = '0;
    slaveHit = 1'b0;
    vecD     = masterBase + LAST_OFS;
    if (useSlave) begin
      if (sPick.found) begin
        vecD             = slaveBase + VEC_W'(sPick.idx);
        sAck[sPick.idx]  = 1'b1;
        mAck             = CAS_BIT;
        slaveHit         = 1'b1;
      end else begin
        vecD = slaveBase + LAST_OFS;
      end
    end else if (mPick.found) begin
      vecD            = masterBase + VEC_W'(mPick.idx);
      mAck[mPick.idx] = 1'b1;
    end
  end

  // next-state of request / in-service registers
  bankVec_t mReqClr, sReqClr, sAfter, mReqD, sReqD, mIsrD, sIsrD;
  logic     casCheck, casDrop;

  always_comb begin
    mReqClr  = stb.ackStb ? (mAck & ~mTrig & ~CAS_BIT) : '0;
    sReqClr  = stb.ackStb ? (sAck & ~sTrig) : '0;
    sAfter   = sReq & ~sReqClr & ~stb.lowerS;
    casCheck = (stb.ackStb && slaveHit) || (|stb.lowerS);
    casDrop  = casCheck && ((sAfter & ~slaveMask) == '0);
    mReqD    = (mReq & ~mReqClr & ~stb.lowerM & ~(casDrop ? CAS_BIT : '0))
               | stb.raiseM;
    sReqD    = sAfter | stb.raiseS;
    mIsrD    = (mIsr & ~stb.clrM) | (stb.ackStb ? mAck : '0);
    sIsrD    = (sIsr & ~stb.clrS) | (stb.ackStb ? sAck : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mReq  <= '0;
      sReq  <= '0;
      mIsr  <= '0;
      sIsr  <= '0;
      mTrig <= '0;
      sTrig <= '0;
      vecQ  <= '0;
    end else begin
      mReq <= mReqD;
      sReq <= sReqD;
      mIsr <= mIsrD;
      sIsr <= sIsrD;
      if (stb.trigWrM) mTrig <= trigWrData & TRIG_MASK_M;
      if (stb.trigWrS) sTrig <= trigWrData & TRIG_MASK_S;
      if (stb.ackStb)  vecQ  <= vecD;
    end
  end

  assign intPending      = (|mUnm) || (|sUnm);
  assign vector          = vecQ;
  assign masterReq       = mReq;
  assign slaveReq        = sReq;
  assign masterInService = mIsr;
  assign slaveInService  = sIsr;
  assign masterTrig      = mTrig;
  assign slaveTrig       = sTrig;

endmodule

// File: rtl/cascade_irq_arbiter.sv
module cascade_irq_arbiter
  import cascade_arb_pkg::*;
#(
  parameter int       VEC_W        = 8,
  parameter int       CASCADE_LINE = 2,
  parameter bankVec_t TRIG_MASK_M  = 8'hF8,
  parameter bankVec_t TRIG_MASK_S  = 8'hDE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  raiseValid,
  input  logic [LINE_W-1:0]     raiseLine,
  input  logic                  lowerValid,
  input  logic [LINE_W-1:0]     lowerLine,
  input  logic [BANK_LINES-1:0] masterMask,
  input  logic [BANK_LINES-1:0] slaveMask,
  input  logic [VEC_W-1:0]      masterBase,
  input  logic [VEC_W-1:0]      slaveBase,
  input  logic                  ack,
  input  logic                  isrClrEn,
  input  logic                  isrClrSel,
  input  logic [BANK_LINES-1:0] isrClrMask,
  input  logic                  trigWrEn,
  input  logic                  trigWrSel,
  input  logic [BANK_LINES-1:0] trigWrData,
  output logic                  intPending,
  output logic [VEC_W-1:0]      vector,
  output logic [BANK_LINES-1:0] masterReq,
  output logic [BANK_LINES-1:0] slaveReq,
  output logic [BANK_LINES-1:0] masterInService,
  output logic [BANK_LINES-1:0] slaveInService,
  output logic [BANK_LINES-1:0] masterTrig,
  output logic [BANK_LINES-1:0] slaveTrig
);

  arbStrobes_t stb;

  arb_ctrl #(.CASCADE_LINE(CASCADE_LINE)) u_ctrl (
    .raiseValid (raiseValid),
    .raiseLine  (raiseLine),
    .lowerValid (lowerValid),
    .lowerLine  (lowerLine),
    .ack        (ack),
    .isrClrEn   (isrClrEn),
    .isrClrSel  (isrClrSel),
    .isrClrMask (isrClrMask),
    .trigWrEn   (trigWrEn),
    .trigWrSel  (trigWrSel),
    .stb        (stb)
  );

  arb_datapath #(
    .VEC_W        (VEC_W),
    .CASCADE_LINE (CASCADE_LINE),
    .TRIG_MASK_M  (TRIG_MASK_M),
    .TRIG_MASK_S  (TRIG_MASK_S)
  ) u_dp (
    .clk             (clk),
    .rst_n           (rst_n),
    .stb             (stb),
    .masterMask      (masterMask),
    .slaveMask       (slaveMask),
    .masterBase      (masterBase),
    .slaveBase       (slaveBase),
    .trigWrData      (trigWrData),
    .intPending      (intPending),
    .vector          (vector),
    .masterReq       (masterReq),
    .slaveReq        (slaveReq),
    .masterInService (masterInService),
    .slaveInService  (slaveInService),
    .masterTrig      (masterTrig),
    .slaveTrig       (slaveTrig)
  );

endmodule

// File: rtl/cascade_irq_arbiter_checker.sv
module cascade_irq_arbiter_checker #(
  parameter logic [7:0] TRIG_MASK_M = 8'hF8,
  parameter logic [7:0] TRIG_MASK_S = 8'hDE
) (
  input logic       clk,
  input logic       rst_n,
  input logic       raiseValid,
  input logic [4:0] raiseLine,
  input logic       lowerValid,
  input logic       ack,
  input logic       isrClrEn,
  input logic       isrClrSel,
  input logic [7:0] isrClrMask,
  input logic [7:0] masterMask,
  input logic       intPending,
  input logic [7:0] vector,
  input logic [7:0] masterReq,
  input logic [7:0] slaveReq,
  input logic [7:0] masterInService,
  input logic [7:0] masterTrig,
  input logic [7:0] slaveTrig
);

  // R1: primary-line raise lands in the primary request register
  p_raise_master_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (raiseValid && raiseLine < 5'd8) |=> masterReq[$past(raiseLine[2:0])]);

  // R1: secondary-line raise also sets the cascade input
  p_raise_cascade_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (raiseValid && raiseLine[4:3] == 2'b01)
      |=> (masterReq[2] && slaveReq[$past(raiseLine[2:0])]));

  // R2: out-of-range raise with no other activity changes nothing
  p_out_of_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raiseValid && raiseLine[4] && !lowerValid && !ack)
      |=> ($stable(masterReq) && $stable(slaveReq)));

  // R3: no requests at all means nothing pending
  p_idle_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (masterReq == 8'h00 && slaveReq == 8'h00) |-> !intPending);

  // R4: vector only moves on acknowledge
  p_vector_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(vector));

  // R5: line 0 unmasked always wins and goes in service
  p_ack_line0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !isrClrEn && masterReq[0] && !masterMask[0]) |=> masterInService[0]);

  // R9: reserved lines never hold level mode
  p_trig_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((masterTrig & ~TRIG_MASK_M) == 8'h00) && ((slaveTrig & ~TRIG_MASK_S) == 8'h00));

  // R10: primary clear without acknowledge removes the selected bits
  p_isr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (isrClrEn && !isrClrSel && !ack)
      |=> ((masterInService & $past(isrClrMask)) == 8'h00));

endmodule

bind cascade_irq_arbiter cascade_irq_arbiter_checker #(
  .TRIG_MASK_M (TRIG_MASK_M),
  .TRIG_MASK_S (TRIG_MASK_S)
) u_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .raiseValid      (raiseValid),
  .raiseLine       (raiseLine),
  .lowerValid      (lowerValid),
  .ack             (ack),
  .isrClrEn        (isrClrEn),
  .isrClrSel       (isrClrSel),
  .isrClrMask      (isrClrMask),
  .masterMask      (masterMask),
  .intPending      (intPending),
  .vector          (vector),
  .masterReq       (masterReq),
  .slaveReq        (slaveReq),
  .masterInService (masterInService),
  .masterTrig      (masterTrig),
  .slaveTrig       (slaveTrig)
);

// File: tb/cascade_irq_arbiter_bench.sv
module cascade_irq_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raiseValid = 1'b0;
  logic [4:0] raiseLine = '0;
  logic       lowerValid = 1'b0;
  logic [4:0] lowerLine = '0;
  logic [7:0] masterMask = '0;
  logic [7:0] slaveMask = '0;
  logic [7:0] masterBase = 8'h20;
  logic [7:0] slaveBase = 8'h28;
  logic       ack = 1'b0;
  logic       isrClrEn = 1'b0;
  logic       isrClrSel = 1'b0;
  logic [7:0] isrClrMask = '0;
  logic       trigWrEn = 1'b0;
  logic       trigWrSel = 1'b0;
  logic [7:0] trigWrData = '0;
  logic       intPending;
  logic [7:0] vector, masterReq, slaveReq, masterInService, slaveInService;
  logic [7:0] masterTrig, slaveTrig;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];

  always #2 clk = ~clk;

  cascade_irq_arbiter u_cascade_irq_arbiter (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic raise(input logic [4:0] line);
    @(negedge clk); raiseValid = 1'b1; raiseLine = line;
    @(negedge clk); raiseValid = 1'b0;
  endtask

  task automatic lower(input logic [4:0] line);
    @(negedge clk); lowerValid = 1'b1; lowerLine = line;
    @(negedge clk); lowerValid = 1'b0;
  endtask

  task automatic trigWrite(input logic sel, input logic [7:0] d);
    @(negedge clk); trigWrEn = 1'b1; trigWrSel = sel; trigWrData = d;
    @(negedge clk); trigWrEn = 1'b0;
  endtask

  task automatic isrClear(input logic sel, input logic [7:0] m);
    @(negedge clk); isrClrEn = 1'b1; isrClrSel = sel; isrClrMask = m;
    @(negedge clk); isrClrEn = 1'b0;
  endtask

  // driver: record the expected vector, then strobe acknowledge
  task automatic ackExpect(input logic [7:0] exp);
    expQ.push_back(exp);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  // monitor: compare the vector after each acknowledge edge
  initial begin
    forever begin
      @(posedge clk);
      if (ack) begin
        @(negedge clk);
        if (expQ.size() == 0) chk("R4 unexpected ack", vector, 8'hxx);
        else chk("R4 vector", vector, expQ.pop_front());
      end
    end
  end

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 vector", vector, 8'h00);
    chk("R11 pending", {7'b0, intPending}, 8'h00);
    chk("R11 masterReq", masterReq, 8'h00);
    chk("R11 masterTrig", masterTrig, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 masked trigger-mode writes
    trigWrite(1'b0, 8'hFF);
    chk("R9 master trig", masterTrig, 8'hF8);
    trigWrite(1'b1, 8'hFF);
    chk("R9 slave trig", slaveTrig, 8'hDE);
    trigWrite(1'b0, 8'h00);
    trigWrite(1'b1, 8'h00);
    chk("R9 slave trig cleared", slaveTrig, 8'h00);

    // R1 raise mapping, R3 pending
    raise(5'd5);
    chk("R1 master line 5", masterReq, 8'h20);
    raise(5'd12);
    chk("R1 slave line 12", slaveReq, 8'h10);
    chk("R1 cascade bit", masterReq, 8'h24);
    chk("R3 pending", {7'b0, intPending}, 8'h01);

    // R4/R5/R6/R7 cascade winner, edge mode
    ackExpect(8'h2C);
    chk("R5 master isr", masterInService, 8'h04);
    chk("R5 slave isr", slaveInService, 8'h10);
    chk("R6 slave edge cleared", slaveReq, 8'h00);
    chk("R7 cascade dropped", masterReq, 8'h20);
    ackExpect(8'h25);
    chk("R5 master isr line5", masterInService, 8'h24);
    chk("R6 master edge cleared", masterReq, 8'h00);
    repeat (3) @(negedge clk);
    chk("R4 vector held", vector, 8'h25);

    // R10 in-service clear
    isrClear(1'b0, 8'h04);
    chk("R10 master clear", masterInService, 8'h20);
    isrClear(1'b1, 8'hFF);
    chk("R10 slave clear", slaveInService, 8'h00);

    // R8 spurious with nothing pending
    ackExpect(8'h27);
    chk("R8 isr untouched", masterInService, 8'h20);

    // R6 level mode keeps request and cascade
    trigWrite(1'b1, 8'h10);
    raise(5'd12);
    ackExpect(8'h2C);
    chk("R6 level kept", slaveReq, 8'h10);
    chk("R7 cascade kept", masterReq, 8'h04);
    // R7 lower drops cascade
    lower(5'd12);
    chk("R7 lower clears slave", slaveReq, 8'h00);
    chk("R7 lower drops cascade", masterReq, 8'h00);
    chk("R3 no pending", {7'b0, intPending}, 8'h00);

    // R2 out-of-range and raise-over-lower
    raise(5'd20);
    chk("R2 out of range master", masterReq, 8'h00);
    chk("R2 out of range slave", slaveReq, 8'h00);
    @(negedge clk); raiseValid = 1'b1; raiseLine = 5'd3;
    lowerValid = 1'b1; lowerLine = 5'd3;
    @(negedge clk); raiseValid = 1'b0; lowerValid = 1'b0;
    chk("R2 raise wins", masterReq, 8'h08);
    lower(5'd3);
    chk("R2 lower clears", masterReq, 8'h00);

    isrClear(1'b0, 8'hFF);
    isrClear(1'b1, 8'hFF);

    // R8 cascade wins but secondary fully masked
    raise(5'd9);
    @(negedge clk); slaveMask = 8'h02;
    @(negedge clk);
    chk("R3 pending via cascade", {7'b0, intPending}, 8'h01);
    ackExpect(8'h2F);
    chk("R8 cascade spurious no isr", masterInService, 8'h00);
    chk("R8 slave req kept", slaveReq, 8'h02);

    // R4 fall-through when primary side masked
    @(negedge clk); masterMask = 8'h04; slaveMask = 8'h00;
    ackExpect(8'h29);
    chk("R5 fallthrough master isr", masterInService, 8'h04);
    chk("R5 fallthrough slave isr", slaveInService, 8'h02);
    chk("R7 fallthrough cascade drop", masterReq, 8'h00);

    // R4 priority among primary lines, R6 primary level
    @(negedge clk); masterMask = 8'h00;
    trigWrite(1'b0, 8'h40);
    raise(5'd6);
    raise(5'd1);
    ackExpect(8'h21);
    ackExpect(8'h26);
    chk("R6 master level kept", masterReq, 8'h40);
    chk("R5 master isr", masterInService, 8'h46);

    repeat (2) @(negedge clk);
    chk("R4 scoreboard drained", 8'(expQ.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    finished = 1'b1;
    $finish;
  end

endmodule